// File: doc/BRIEF.md
# Burst Address Sequencer

This block generates the word address presented to a synchronous burst memory. A burst opens when a load strobe is seen on a rising clock edge. There are two such strobes, one from the processor and one from the cache controller. On that edge the sequencer captures a 17-bit word address. The captured address drives the output starting in the following cycle, with the beat index at zero.

After the load, each cycle that samples the advance input high moves the burst forward by one beat. The two low address bits follow the selected ordering, and the upper fifteen bits keep the loaded value. The ordering input selects the sequence. Linear order adds the beat count to the starting low bits, modulo four. Interleaved order XORs the beat count into the starting low bits. When the ordering input is not otherwise used, the surrounding logic ties it high, which selects interleaved order. The memory array, the data path and chip-enable decoding sit outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: After synchronous reset, addr_out is 0 and beat is 0. Until the first load strobe, step has no effect on either output.
- R2: When proc_strobe is high at a rising edge, addr_out equals the sampled addr_in and beat is 0 from the next cycle on.
- R3: cache_strobe loads addr_in in the same way as proc_strobe. When both strobes are high in one cycle, the processor strobe takes priority and a single load of addr_in occurs.
- R4: With no strobe, step high at an edge increments beat by one, modulo 4. With step low, beat and addr_out hold.
- R5: With order_sel sampled 0 at the load, the two low address bits equal (start + beat) mod 4.
- R6: With order_sel sampled 1 at the load, the two low address bits equal start XOR beat.
- R7: Bits 16:2 of addr_out keep the loaded value for as long as no new strobe arrives.
- R8: A step taken on beat 3 returns beat to 0 and returns addr_out to the loaded start address.
- R9: A strobe in the same cycle as step restarts the burst at the new addr_in with beat 0. The step is discarded.
- R10: order_sel and addr_in are used only on a load edge. Changes to them during a burst have no effect on addr_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| proc_strobe | input | 1 | Processor load strobe, higher priority |
| cache_strobe | input | 1 | Cache-controller load strobe |
| step | input | 1 | Advance to the next beat |
| order_sel | input | 1 | 0 selects linear order, 1 selects interleaved order (tie high when unused) |
| addr_in | input | 17 | Start address captured on a load |
| addr_out | output | 17 | Current burst word address |
| beat | output | 2 | Beat index within the burst |

## Verification
Three events can fall on the same clock edge: a load from either strobe, a step, and a change of the ordering input. The bench asserts both strobes together in one cycle. It expects a single load of addr_in, which shows that nothing is counted twice. It also raises step in the same cycle as a new strobe during a running burst. It judges that cycle by the restart: beat 0 at the new address, with no step applied. Every burst also flips order_sel and scrambles addr_in right after the load. The expected sequence must still follow the ordering captured at the load.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    localparam int unsigned ADDR_W_DEF = 17;
    localparam int unsigned BEAT_W_DEF = 2;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_PROC  = 2'd1,
        SRC_CACHE = 2'd2
    } strobe_src_e;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef struct packed {
        logic        load;
        strobe_src_e src;
    } strobe_req_t;

    // Fixed priority: the processor strobe wins over the cache strobe.
    function automatic strobe_src_e pick_src(input logic p, input logic c);
        if (p)      return SRC_PROC;
        else if (c) return SRC_CACHE;
        else        return SRC_NONE;
    endfunction

endpackage

// File: rtl/bseq_strobe_arb.sv
module bseq_strobe_arb
    import bseq_pkg::*;
(
    input  logic        proc_strobe,
    input  logic        cache_strobe,
    output strobe_req_t req
);
    always_comb begin
        req.src  = pick_src(proc_strobe, cache_strobe);
        req.load = (req.src != SRC_NONE);
    end
endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
    parameter int unsigned BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              advance,
    output logic [BEAT_W-1:0] beat
);
    localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

    logic [BEAT_W-1:0] beat_q;

    always_ff @(posedge clk) begin
        if (rst)          beat_q <= '0;
        else if (restart) beat_q <= '0;
        else if (advance) beat_q <= beat_q + ONE;
    end

    assign beat = beat_q;

    // R4: an advance without a restart moves the beat forward by one, wrapping
    a_r4_advance_inc: assert property (@(posedge clk) disable iff (rst)
        (advance && !restart) |=> (beat_q == $past(beat_q) + ONE));

    // R9: a restart always brings the beat back to zero, even with an advance
    a_r9_restart_zero: assert property (@(posedge clk) disable iff (rst)
        restart |=> (beat_q == '0));
endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map
    import bseq_pkg::*;
#(
    parameter int unsigned BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] base,
    input  logic [BEAT_W-1:0] beat,
    input  order_e            ord,
    output logic [BEAT_W-1:0] low
);
    logic [BEAT_W-1:0] lin_low;
    logic [BEAT_W-1:0] ilv_low;

    // Linear ordering: modular add of the beat count
    assign lin_low = base + beat;

    // Interleaved ordering: bitwise XOR of the beat count
    for (genvar i = 0; i < int'(BEAT_W); i++) begin : g_ilv_bit
        assign ilv_low[i] = base[i] ^ beat[i];
    end

    assign low = (ord == ORD_INTERLEAVE) ? ilv_low : lin_low;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bseq_pkg::*;
#(
    parameter int unsigned ADDR_W = ADDR_W_DEF,
    parameter int unsigned BEAT_W = BEAT_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              proc_strobe,
    input  logic              cache_strobe,
    input  logic              step,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [BEAT_W-1:0] beat
);
    localparam int unsigned HI_W = ADDR_W - BEAT_W;
    localparam logic [BEAT_W-1:0] LAST_BEAT = {BEAT_W{1'b1}};

    strobe_req_t       req;
    logic              active_q;
    order_e            ord_q;
    logic [HI_W-1:0]   hi_q;
    logic [BEAT_W-1:0] base_q;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] low;
    logic              adv;

    bseq_strobe_arb u_arb (
        .proc_strobe (proc_strobe),
        .cache_strobe(cache_strobe),
        .req         (req)
    );

    assign adv = step && active_q;

    bseq_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .restart(req.load),
        .advance(adv),
        .beat   (beat_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            ord_q    <= ORD_INTERLEAVE;
            hi_q     <= '0;
            base_q   <= '0;
        end else if (req.load) begin
            active_q <= 1'b1;
            ord_q    <= order_e'(order_sel);
            hi_q     <= addr_in[ADDR_W-1:BEAT_W];
            base_q   <= addr_in[BEAT_W-1:0];
        end
    end

    bseq_order_map #(.BEAT_W(BEAT_W)) u_map (
        .base(base_q),
        .beat(beat_q),
        .ord (ord_q),
        .low (low)
    );

    assign addr_out = {hi_q, low};
    assign beat     = beat_q;

    // R1: before any load the outputs rest at zero
    a_r1_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !active_q |-> (addr_out == '0 && beat == '0));

    // R2: a processor strobe loads the sampled address
    a_r2_proc_load: assert property (@(posedge clk) disable iff (rst)
        proc_strobe |=> (addr_out == $past(addr_in) && beat == '0));

    // R3: the cache strobe alone also loads the sampled address
    a_r3_cache_load: assert property (@(posedge clk) disable iff (rst)
        (cache_strobe && !proc_strobe) |=> (addr_out == $past(addr_in)));

    // R7: the upper bits do not move without a strobe
    a_r7_upper_stable: assert property (@(posedge clk) disable iff (rst)
        !req.load |=> $stable(addr_out[ADDR_W-1:BEAT_W]));

    // R4: no strobe and no step means the outputs hold
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (!req.load && !step) |=> ($stable(addr_out) && $stable(beat)));

    // R8: a step on the last beat returns to the start address
    a_r8_wrap_start: assert property (@(posedge clk) disable iff (rst)
        (active_q && step && !req.load && beat == LAST_BEAT)
        |=> (addr_out == {hi_q, base_q} && beat == '0));

    // R10: the captured ordering changes only on a load
    a_r10_order_held: assert property (@(posedge clk) disable iff (rst)
        !req.load |=> $stable(ord_q));
endmodule

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        proc_strobe = 1'b0;
    logic        cache_strobe = 1'b0;
    logic        step = 1'b0;
    logic        order_sel = 1'b1;
    logic [16:0] addr_in = '0;
    logic [16:0] addr_out;
    logic [1:0]  beat;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    burst_addr_seq u_burst_addr_seq (
        .clk         (clk),
        .rst         (rst),
        .proc_strobe (proc_strobe),
        .cache_strobe(cache_strobe),
        .step        (step),
        .order_sel   (order_sel),
        .addr_in     (addr_in),
        .addr_out    (addr_out),
        .beat        (beat)
    );

    task automatic chk(input string req, input logic [16:0] a_exp, input logic [1:0] b_exp);
        checks++;
        if (addr_out !== a_exp || beat !== b_exp) begin
            failures++;
            $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                     req, addr_out, beat, a_exp, b_exp);
        end
    endtask

    function automatic logic [1:0] exp_low(input logic ord, input logic [1:0] s, input logic [1:0] b);
        return ord ? (s ^ b) : 2'((s + b) % 4);
    endfunction

    // one clock: inputs set before the edge, outputs sampled at the following falling edge
    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [14:0] up;
        logic [14:0] up2;
        repeat (3) tick();
        chk("R1 reset", 17'h0, 2'd0);
        rst = 1'b0;
        step = 1'b1;
        addr_in = 17'h1abcd;
        repeat (3) begin
            tick();
            chk("R1 step before load", 17'h0, 2'd0);
        end
        step = 1'b0;

        for (int ord = 0; ord < 2; ord++) begin
            for (int s = 0; s < 4; s++) begin
                for (int kind = 0; kind < 3; kind++) begin
                    up = 15'(((ord * 12 + s * 3 + kind) * 2731 + 17) & 32'h7fff);
                    addr_in = {up, 2'(s)};
                    order_sel = ord[0];
                    proc_strobe = (kind != 1);
                    cache_strobe = (kind != 0);
                    tick();
                    chk(kind == 0 ? "R2 proc load" : "R3 cache/both load", {up, 2'(s)}, 2'd0);
                    proc_strobe = 1'b0;
                    cache_strobe = 1'b0;
                    order_sel = ~ord[0];
                    addr_in = ~{up, 2'(s)};
                    for (int k = 1; k <= 5; k++) begin
                        if (k == 2) begin
                            step = 1'b0;
                            tick();
                            chk("R4 hold", {up, exp_low(ord[0], 2'(s), 2'd1)}, 2'd1);
                        end
                        step = 1'b1;
                        tick();
                        chk(k == 4 ? "R8 wrap" : (ord == 0 ? "R5 R7 R10 linear" : "R6 R7 R10 interleave"),
                            {up, exp_low(ord[0], 2'(s), 2'(k % 4))}, 2'(k % 4));
                    end
                    step = 1'b0;
                end
            end
        end

        // R9: a strobe together with step restarts the burst mid-way
        up2 = 15'h2a5a;
        addr_in = {up2, 2'd3};
        order_sel = 1'b0;
        proc_strobe = 1'b1;
        tick();
        proc_strobe = 1'b0;
        step = 1'b1;
        tick();
        chk("R9 pre-restart beat", {up2, 2'd0}, 2'd1);
        addr_in = {up2 ^ 15'h7fff, 2'd1};
        order_sel = 1'b1;
        cache_strobe = 1'b1;
        tick();
        chk("R9 restart with step", {up2 ^ 15'h7fff, 2'd1}, 2'd0);
        cache_strobe = 1'b0;
        tick();
        chk("R9 R6 after restart", {up2 ^ 15'h7fff, 2'd0}, 2'd1);
        step = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule